// File: doc/BRIEF.md
# Branch Target and Return Unit

This block resolves the next program counter for the unconditional control-flow operations of an 8-bit accumulator machine with a 16-bit program space. The decoder hands it an operation class, the opcode byte, up to two operand bytes, the address of the instruction that follows, and the current accumulator and 16-bit data pointer. Plain jumps resolve in one cycle. Calls spill their return address into a byte-wide stack memory, and returns read it back, over a small read/write port.

The unit also keeps a two-deep record of nested interrupt service. Interrupt entry marks one more level as active. Return-from-interrupt retires the innermost level as it hands back the saved address.

Operation classes on `op_kind`: 0 short relative, 1 long jump, 2 page-absolute (opcode low bits pick jump or call), 3 pointer-plus-accumulator indirect, 4 long call, 5 return, 6 return-from-interrupt, 7 reserved.

Top module: `branch_target_unit`

## Requirements
- R1: Class 0 (short relative) gives `nxt_pc` = `seq_pc` + `op_b1` taken as a signed byte, modulo 65536, with `pc_vld` high in the cycle after the operation is accepted.
- R2: Class 1 (long jump) gives `nxt_pc` = {`op_b1`, `op_b2`}, with `op_b1` as the high byte, one cycle after acceptance.
- R3: Class 2 with `op_code[4:0]` = 5'b00001 is a page jump: `nxt_pc` = {`seq_pc[15:11]`, `op_code[7:5]`, `op_b1`}, one cycle after acceptance, so the upper 5 bits of the following address are kept.
- R4: Class 3 (indirect) gives `nxt_pc` = `dptr` + `acc`, with `acc` unsigned and the sum taken modulo 65536, one cycle after acceptance.
- R5: Class 4 (long call, target {`op_b1`, `op_b2`}) and class 2 with `op_code[4:0]` = 5'b10001 (page call, target formed as in R3) store `seq_pc` as the return address and present the target on `nxt_pc` with `pc_vld` three cycles after acceptance.
- R6: A call writes in two consecutive cycles, starting the cycle after acceptance: first `seq_pc[7:0]` at stack pointer + 1, then `seq_pc[15:8]` at stack pointer + 2. The stack pointer ends 2 higher and is 8'h07 after reset. Reads and writes never occur in the same cycle.
- R7: Class 5 (return) reads the stack at the stack pointer and then at the stack pointer - 1, in the two cycles after acceptance. It drives `nxt_pc` = {first byte read, second byte read} with `pc_vld` four cycles after acceptance, and leaves the stack pointer 2 lower.
- R8: Class 6 (return-from-interrupt) behaves exactly as R7 and, in the cycle `pc_vld` rises, also retires the innermost active interrupt level. With no level active it matches R7 completely.
- R9: A one-cycle `irq_enter` activates the next level one cycle later. `irq_lvl` only takes the thermometer values 2'b00, 2'b01, 2'b11 and holds at 2'b11.
- R10: `busy` is high from the cycle after a call or return is accepted until the cycle before its `pc_vld`. It is never high together with `pc_vld`, and `op_valid` is accepted only while `busy` is low.
- R11: Class 7, and class 2 with `op_code[4:0]` other than 5'b00001 and 5'b10001, produce no `pc_vld`, no stack access and no `busy`.
- R12: After reset `nxt_pc` is 16'h0000 and `pc_vld`, `busy`, `stk_we`, `stk_re` and `irq_lvl` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| op_valid | input | 1 | Operation present this cycle |
| op_kind | input | 3 | Operation class |
| op_code | input | 8 | Opcode byte (page bits and page form select) |
| op_b1 | input | 8 | First operand byte |
| op_b2 | input | 8 | Second operand byte |
| seq_pc | input | 16 | Address of the following instruction |
| acc | input | 8 | Accumulator value |
| dptr | input | 16 | Data pointer value |
| irq_enter | input | 1 | Interrupt service entered |
| stk_rdata | input | 8 | Stack read data, valid the cycle after a read |
| nxt_pc | output | 16 | Resolved next program counter |
| pc_vld | output | 1 | `nxt_pc` updated this cycle |
| busy | output | 1 | Multi-cycle call or return in progress |
| stk_we | output | 1 | Stack write strobe |
| stk_re | output | 1 | Stack read strobe |
| stk_addr | output | 8 | Stack address |
| stk_wdata | output | 8 | Stack write data |
| irq_lvl | output | 2 | Active interrupt levels, thermometer coded |

## Verification
Short offsets are driven forward, backward and across both ends of the address space, which separates sign extension from zero extension and shows the wrap. Page forms use following addresses whose upper bits differ from the opcode bits, so any loss of the kept 5 bits or any misplacement of the 3 opcode bits changes the result. Nested calls followed by returns in reverse order show the byte order and the pointer direction, because a swapped byte or a wrong slot returns to another address. Return-from-interrupt is tried with two levels active, with one level active and with none, and reserved codes check that nothing moves.

// File: rtl/btu_pkg.sv
package btu_pkg;
  localparam int PC_W = 16;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    K_SHORT = 3'd0, K_LONG = 3'd1, K_PAGE = 3'd2, K_IND = 3'd3,
    K_LCALL = 3'd4, K_RET  = 3'd5, K_RETI = 3'd6, K_RSVD = 3'd7
  } kind_e;

  typedef enum logic [2:0] {
    A_NONE, A_JUMP, A_CALL, A_RET, A_RETI
  } act_e;

  typedef enum logic [2:0] {
    S_IDLE, S_PUSH_LO, S_PUSH_HI, S_POP_HI, S_POP_LO, S_POP_END
  } st_e;

  localparam logic [4:0] PAGE_JMP_PAT  = 5'b00001;
  localparam logic [4:0] PAGE_CALL_PAT = 5'b10001;

  // Which action a decoded class asks for
  function automatic act_e classify(kind_e k, logic [BYTE_W-1:0] opc);
    case (k)
      K_SHORT, K_LONG, K_IND: classify = A_JUMP;
      K_LCALL:                classify = A_CALL;
      K_RET:                  classify = A_RET;
      K_RETI:                 classify = A_RETI;
      K_PAGE: begin
        if (opc[4:0] == PAGE_JMP_PAT)       classify = A_JUMP;
        else if (opc[4:0] == PAGE_CALL_PAT) classify = A_CALL;
        else                                classify = A_NONE;
      end
      default:                classify = A_NONE;
    endcase
  endfunction

  function automatic logic [PC_W-1:0] rel_target(logic [PC_W-1:0] seq,
                                                 logic [BYTE_W-1:0] off);
    rel_target = seq + {{(PC_W-BYTE_W){off[BYTE_W-1]}}, off};
  endfunction

  function automatic logic [PC_W-1:0] page_target(logic [PC_W-1:0] seq,
                                                  logic [BYTE_W-1:0] opc,
                                                  logic [BYTE_W-1:0] lo);
    page_target = {seq[PC_W-1:11], opc[7:5], lo};
  endfunction

  function automatic logic [PC_W-1:0] ind_target(logic [PC_W-1:0] ptr,
                                                 logic [BYTE_W-1:0] a);
    ind_target = ptr + {{(PC_W-BYTE_W){1'b0}}, a};
  endfunction

  function automatic logic [PC_W-1:0] calc_target(kind_e k,
      logic [BYTE_W-1:0] opc, logic [BYTE_W-1:0] b1, logic [BYTE_W-1:0] b2,
      logic [PC_W-1:0] seq, logic [PC_W-1:0] ptr, logic [BYTE_W-1:0] a);
    case (k)
      K_SHORT:         calc_target = rel_target(seq, b1);
      K_LONG, K_LCALL: calc_target = {b1, b2};
      K_PAGE:          calc_target = page_target(seq, opc, b1);
      K_IND:           calc_target = ind_target(ptr, a);
      default:         calc_target = seq;
    endcase
  endfunction
endpackage

// File: rtl/btu_target.sv
module btu_target
  import btu_pkg::*;
(
  input  logic [2:0]        kind,
  input  logic [BYTE_W-1:0] opc,
  input  logic [BYTE_W-1:0] b1,
  input  logic [BYTE_W-1:0] b2,
  input  logic [PC_W-1:0]   seq,
  input  logic [BYTE_W-1:0] acc,
  input  logic [PC_W-1:0]   dptr,
  output logic [PC_W-1:0]   target,
  output act_e              act
);
  kind_e k;
  always_comb begin
    k      = kind_e'(kind);
    act    = classify(k, opc);
    target = calc_target(k, opc, b1, b2, seq, dptr, acc);
  end
endmodule

// File: rtl/btu_stack_seq.sv
module btu_stack_seq
  import btu_pkg::*;
#(
  parameter int SP_W = 8,
  parameter logic [SP_W-1:0] SP_RST = 8'h07
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  act_e              act,
  input  logic [PC_W-1:0]   target,
  input  logic [PC_W-1:0]   seq,
  input  logic [BYTE_W-1:0] rdata,
  output logic [PC_W-1:0]   nxt_pc,
  output logic              pc_vld,
  output logic              busy,
  output logic              we,
  output logic              re,
  output logic [SP_W-1:0]   addr,
  output logic [BYTE_W-1:0] wdata,
  output logic              reti_done
);
  localparam logic [SP_W-1:0] SP_ONE = {{(SP_W-1){1'b0}}, 1'b1};

  st_e               st;
  logic [SP_W-1:0]   sp;
  logic [PC_W-1:0]   ret_q, tgt_q;
  logic [BYTE_W-1:0] hi_q;
  logic              is_reti;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      sp      <= SP_RST;
      ret_q   <= '0;
      tgt_q   <= '0;
      hi_q    <= '0;
      is_reti <= 1'b0;
      nxt_pc  <= '0;
      pc_vld  <= 1'b0;
    end else begin
      pc_vld <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          case (act)
            A_JUMP: begin
              nxt_pc <= target;
              pc_vld <= 1'b1;
            end
            A_CALL: begin
              tgt_q <= target;
              ret_q <= seq;
              st    <= S_PUSH_LO;
            end
            A_RET, A_RETI: begin
              is_reti <= (act == A_RETI);
              st      <= S_POP_HI;
            end
            default: ;
          endcase
        end
        S_PUSH_LO: begin
          sp <= sp + SP_ONE;
          st <= S_PUSH_HI;
        end
        S_PUSH_HI: begin
          sp     <= sp + SP_ONE;
          nxt_pc <= tgt_q;
          pc_vld <= 1'b1;
          st     <= S_IDLE;
        end
        S_POP_HI: begin
          sp <= sp - SP_ONE;
          st <= S_POP_LO;
        end
        S_POP_LO: begin
          sp   <= sp - SP_ONE;
          hi_q <= rdata;
          st   <= S_POP_END;
        end
        S_POP_END: begin
          nxt_pc <= {hi_q, rdata};
          pc_vld <= 1'b1;
          st     <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    we        = (st == S_PUSH_LO) || (st == S_PUSH_HI);
    re        = (st == S_POP_HI) || (st == S_POP_LO);
    addr      = we ? sp + SP_ONE : sp;
    wdata     = (st == S_PUSH_LO) ? ret_q[BYTE_W-1:0] : ret_q[PC_W-1:BYTE_W];
    busy      = (st != S_IDLE);
    reti_done = (st == S_POP_END) && is_reti;
  end
endmodule

// File: rtl/btu_irq_levels.sv
module btu_irq_levels #(
  parameter int NLVL = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enter,
  input  logic            clr,
  output logic [NLVL-1:0] lvl
);
  logic [NLVL-1:0] after_clr, lvl_nx;

  always_comb begin
    after_clr = clr ? (lvl >> 1) : lvl;
    lvl_nx    = enter ? {after_clr[NLVL-2:0], 1'b1} : after_clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl <= '0;
    else        lvl <= lvl_nx;
  end
endmodule

// File: rtl/branch_target_unit.sv
module branch_target_unit
  import btu_pkg::*;
#(
  parameter int NLVL = 2,
  parameter logic [7:0] SP_RST = 8'h07
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        op_valid,
  input  logic [2:0]  op_kind,
  input  logic [7:0]  op_code,
  input  logic [7:0]  op_b1,
  input  logic [7:0]  op_b2,
  input  logic [15:0] seq_pc,
  input  logic [7:0]  acc,
  input  logic [15:0] dptr,
  input  logic        irq_enter,
  input  logic [7:0]  stk_rdata,
  output logic [15:0] nxt_pc,
  output logic        pc_vld,
  output logic        busy,
  output logic        stk_we,
  output logic        stk_re,
  output logic [7:0]  stk_addr,
  output logic [7:0]  stk_wdata,
  output logic [NLVL-1:0] irq_lvl
);
  logic [PC_W-1:0] target;
  act_e            act;
  logic            accept;
  logic            reti_done;

  assign accept = op_valid && !busy;

  btu_target u_target (
    .kind(op_kind), .opc(op_code), .b1(op_b1), .b2(op_b2),
    .seq(seq_pc), .acc(acc), .dptr(dptr), .target(target), .act(act)
  );

  btu_stack_seq #(.SP_W(8), .SP_RST(SP_RST)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(accept), .act(act), .target(target),
    .seq(seq_pc), .rdata(stk_rdata), .nxt_pc(nxt_pc), .pc_vld(pc_vld),
    .busy(busy), .we(stk_we), .re(stk_re), .addr(stk_addr),
    .wdata(stk_wdata), .reti_done(reti_done)
  );

  btu_irq_levels #(.NLVL(NLVL)) u_lvl (
    .clk(clk), .rst_n(rst_n), .enter(irq_enter), .clr(reti_done), .lvl(irq_lvl)
  );
endmodule

// File: rtl/btu_checker.sv
module btu_checker
  import btu_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        accept,
  input act_e        act,
  input logic [2:0]  op_kind,
  input logic [7:0]  op_code,
  input logic [15:0] seq_pc,
  input logic [15:0] nxt_pc,
  input logic        pc_vld,
  input logic        busy,
  input logic        stk_we,
  input logic        stk_re,
  input logic [7:0]  stk_addr,
  input logic        reti_done,
  input logic        irq_enter,
  input logic [1:0]  irq_lvl
);
  AST_JUMP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    accept && act == A_JUMP |=> pc_vld); // R1
  AST_PAGE_KEEP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    accept && op_kind == 3'd2 && op_code[4:0] == 5'b00001
    |=> nxt_pc[15:11] == $past(seq_pc[15:11])); // R3
  AST_NO_RW_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(stk_we && stk_re)); // R6
  AST_PUSH_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
    stk_we && $past(stk_we) |-> stk_addr == $past(stk_addr) + 8'd1); // R6
  AST_POP_DESCEND: assert property (@(posedge clk) disable iff (!rst_n)
    stk_re && $past(stk_re) |-> stk_addr == $past(stk_addr) - 8'd1); // R7
  AST_RETI_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    reti_done && !irq_enter |=> irq_lvl == ($past(irq_lvl) >> 1)); // R8
  AST_LVL_THERMO: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_lvl + 2'd1) & irq_lvl) == 2'd0); // R9
  AST_BUSY_NO_VLD: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !pc_vld); // R10
endmodule

bind branch_target_unit btu_checker u_btu_chk (
  .clk(clk), .rst_n(rst_n), .accept(accept), .act(act), .op_kind(op_kind),
  .op_code(op_code), .seq_pc(seq_pc), .nxt_pc(nxt_pc), .pc_vld(pc_vld),
  .busy(busy), .stk_we(stk_we), .stk_re(stk_re), .stk_addr(stk_addr),
  .reti_done(reti_done), .irq_enter(irq_enter), .irq_lvl(irq_lvl)
);

// File: tb/test_branch_target_unit.sv
`timescale 1ns/1ps
module test_branch_target_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_valid = 1'b0;
  logic [2:0] op_kind = '0;
  logic [7:0] op_code = '0, op_b1 = '0, op_b2 = '0, acc = '0;
  logic [15:0] seq_pc = '0, dptr = '0;
  logic irq_enter = 1'b0;
  logic [7:0] stk_rdata;
  logic [15:0] nxt_pc;
  logic pc_vld, busy, stk_we, stk_re;
  logic [7:0] stk_addr, stk_wdata;
  logic [1:0] irq_lvl;

  always #2 clk = ~clk;

  branch_target_unit i_branch_target_unit (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
    .op_code(op_code), .op_b1(op_b1), .op_b2(op_b2), .seq_pc(seq_pc),
    .acc(acc), .dptr(dptr), .irq_enter(irq_enter), .stk_rdata(stk_rdata),
    .nxt_pc(nxt_pc), .pc_vld(pc_vld), .busy(busy), .stk_we(stk_we),
    .stk_re(stk_re), .stk_addr(stk_addr), .stk_wdata(stk_wdata),
    .irq_lvl(irq_lvl)
  );

  // Stack memory of the environment: synchronous write, registered read
  logic [7:0] ram [256];
  logic [7:0] rd_q = 8'h00;
  assign stk_rdata = rd_q;
  always @(posedge clk) begin
    if (stk_we) ram[stk_addr] <= stk_wdata;
    if (stk_re) rd_q <= ram[stk_addr];
  end

  typedef struct {
    bit vld; logic [15:0] pc; bit we; bit re;
    logic [7:0] addr; logic [7:0] wd; bit busy; int dlvl; string tag;
  } exp_t;

  exp_t q[$];
  int checks = 0, fails = 0, cyc = 0;
  int m_sp = 7, m_lvl = 0;
  logic [15:0] ret_stack[$];
  bit mon_on = 0;

  function automatic exp_t idle(string tag);
    exp_t e;
    e.vld = 0; e.pc = 0; e.we = 0; e.re = 0; e.addr = 0; e.wd = 0;
    e.busy = 0; e.dlvl = 0; e.tag = tag;
    return e;
  endfunction

  task automatic chk(bit ok, string tag, string what, int act_v, int exp_v);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act_v, exp_v);
    end
  endtask

  always @(negedge clk) if (mon_on) begin
    exp_t e;
    int lv;
    e = (q.size() > 0) ? q.pop_front() : idle("R10");
    m_lvl = m_lvl + e.dlvl;
    if (m_lvl < 0) m_lvl = 0;
    if (m_lvl > 2) m_lvl = 2;
    lv = (1 << m_lvl) - 1;
    chk(pc_vld == e.vld, e.tag, "pc_vld", int'(pc_vld), int'(e.vld));
    if (e.vld) chk(nxt_pc == e.pc, e.tag, "nxt_pc", int'(nxt_pc), int'(e.pc));
    chk(busy == e.busy, "R10", "busy", int'(busy), int'(e.busy));
    chk(stk_we == e.we && stk_re == e.re, e.tag, "stk_we/re",
        int'({stk_we, stk_re}), int'({e.we, e.re}));
    if (e.we || e.re) chk(stk_addr == e.addr, e.tag, "stk_addr", int'(stk_addr), int'(e.addr));
    if (e.we) chk(stk_wdata == e.wd, "R6", "stk_wdata", int'(stk_wdata), int'(e.wd));
    chk(int'(irq_lvl) == lv, "R9", "irq_lvl", int'(irq_lvl), lv);
  end

  // Independent restatements of the target arithmetic
  function automatic logic [15:0] m_short(int seq, int off);
    int s = (off >= 128) ? off - 256 : off;
    return 16'((seq + s + 65536) % 65536);
  endfunction
  function automatic logic [15:0] m_page(int seq, int opc, int lo);
    return 16'((seq & 'hF800) | ((opc / 32) * 256) | lo);
  endfunction
  function automatic logic [15:0] m_ind(int p, int a);
    return 16'((p + a) % 65536);
  endfunction

  task automatic issue(int kind, int opc, int b1, int b2, int seq, int a,
                       int p, logic [15:0] exp_pc, string tag);
    exp_t e;
    bit is_page_jmp  = (kind == 2) && ((opc % 32) == 1);
    bit is_page_call = (kind == 2) && ((opc % 32) == 17);
    @(posedge clk); #1;
    op_valid = 1; op_kind = 3'(kind); op_code = 8'(opc); op_b1 = 8'(b1);
    op_b2 = 8'(b2); seq_pc = 16'(seq); acc = 8'(a); dptr = 16'(p);
    q.push_back(idle(tag));
    if (kind <= 1 || kind == 3 || is_page_jmp) begin
      e = idle(tag); e.vld = 1; e.pc = exp_pc; q.push_back(e);
    end else if (kind == 4 || is_page_call) begin
      e = idle("R6"); e.busy = 1; e.we = 1;
      e.addr = 8'((m_sp + 1) % 256); e.wd = 8'(seq % 256); q.push_back(e);
      e.addr = 8'((m_sp + 2) % 256); e.wd = 8'(seq / 256); q.push_back(e);
      e = idle(tag); e.vld = 1; e.pc = exp_pc; q.push_back(e);
      m_sp = (m_sp + 2) % 256;
      ret_stack.push_back(16'(seq));
    end else if (kind == 5 || kind == 6) begin
      e = idle("R7"); e.busy = 1; e.re = 1;
      e.addr = 8'(m_sp); q.push_back(e);
      e.addr = 8'((m_sp + 255) % 256); q.push_back(e);
      e = idle("R7"); e.busy = 1; q.push_back(e);
      e = idle(tag); e.vld = 1; e.pc = ret_stack.pop_back();
      e.dlvl = (kind == 6 && m_lvl > 0) ? -1 : 0;
      q.push_back(e);
      m_sp = (m_sp + 254) % 256;
    end else begin
      q.push_back(idle("R11"));
    end
    @(posedge clk); #1;
    op_valid = 0;
    wait (q.size() == 0);
  endtask

  task automatic irq();
    exp_t e;
    @(posedge clk); #1;
    irq_enter = 1;
    q.push_back(idle("R9"));
    e = idle("R9"); e.dlvl = 1; q.push_back(e);
    @(posedge clk); #1;
    irq_enter = 0;
    wait (q.size() == 0);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R12: reset state
    chk(nxt_pc == 16'h0000 && !pc_vld && !busy && !stk_we && !stk_re && irq_lvl == 2'b00,
        "R12", "reset outputs", int'({nxt_pc, pc_vld, busy, stk_we, stk_re, irq_lvl}), 0);
    rst_n = 1;
    @(negedge clk);
    mon_on = 1;
    // R1 short relative: forward, backward, wrap high, wrap low
    issue(0, 'h80, 'h10, 0, 'h1234, 0, 0, m_short('h1234, 'h10), "R1");
    issue(0, 'h80, 'h80, 0, 'h1234, 0, 0, m_short('h1234, 'h80), "R1");
    issue(0, 'h80, 'h7F, 0, 'hFFF0, 0, 0, m_short('hFFF0, 'h7F), "R1");
    issue(0, 'h80, 'hF0, 0, 'h0005, 0, 0, m_short('h0005, 'hF0), "R1");
    // R2 long jump
    issue(1, 'h02, 'hAB, 'hCD, 'h0100, 0, 0, 16'hABCD, "R2");
    // R3 page jump
    issue(2, 'hA1, 'h5C, 0, 'h4812, 0, 0, m_page('h4812, 'hA1, 'h5C), "R3");
    issue(2, 'h01, 'hFF, 0, 'hF7FF, 0, 0, m_page('hF7FF, 'h01, 'hFF), "R3");
    // R4 indirect, plain and wrapping
    issue(3, 'h73, 0, 0, 0, 'h08, 'h2000, m_ind('h2000, 'h08), "R4");
    issue(3, 'h73, 0, 0, 0, 'hFF, 'hFFFF, m_ind('hFFFF, 'hFF), "R4");
    // R5 nested calls then R7 returns in reverse order
    issue(4, 'h12, 'h50, 'h00, 'h0103, 0, 0, 16'h5000, "R5");
    issue(2, 'hF1, 'h22, 0, 'h5002, 0, 0, m_page('h5002, 'hF1, 'h22), "R5");
    issue(5, 'h22, 0, 0, 'h5724, 0, 0, 16'h0000, "R7");
    issue(5, 'h22, 0, 0, 'h5004, 0, 0, 16'h0000, "R7");
    // R9 nesting and saturation
    irq(); irq(); irq();
    // R8 return-from-interrupt with two levels, one level, none
    issue(4, 'h12, 'h12, 'h34, 'h0A0B, 0, 0, 16'h1234, "R5");
    issue(6, 'h32, 0, 0, 'h1235, 0, 0, 16'h0000, "R8");
    issue(2, 'h11, 'h40, 0, 'h2200, 0, 0, m_page('h2200, 'h11, 'h40), "R5");
    issue(6, 'h32, 0, 0, 'h2041, 0, 0, 16'h0000, "R8");
    issue(4, 'h12, 'hC0, 'h00, 'hBEEF, 0, 0, 16'hC000, "R5");
    issue(6, 'h32, 0, 0, 'hC001, 0, 0, 16'h0000, "R8");
    // R11 ignored codes
    issue(7, 'h00, 'h11, 'h22, 'h3333, 0, 0, 16'h0000, "R11");
    issue(2, 'h02, 'h11, 'h22, 'h3333, 0, 0, 16'h0000, "R11");
    issue(2, 'hE0, 'h11, 'h22, 'h3333, 0, 0, 16'h0000, "R11");
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    finish_run();
  end
endmodule